// File: doc/BRIEF.md
# Serial Transmitter with FIFO Level DMA Request

This block sends bytes on an asynchronous serial line. Bytes arrive through a single-beat write port into a 16-entry transmit queue. Each byte goes out as one frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The frame has no parity bit.

The bit rate comes from a peripheral clock. A 2-bit prescaler code n divides that clock by 4^n. An 8-bit divider value N then divides it by N + 1. A fixed oversampling count of 32 completes the bit period.

A DMA engine keeps the queue topped up. The block raises a request while the queue fill level is at or below a programmable trigger level. The request drops for one cycle after every accepted write, so an engine that samples the level cannot count one request twice. A copy of the request, gated by an interrupt enable, serves as the transmit interrupt. A queue-clear input empties the queue, and a sticky flag records any write lost to a full queue.

Top module: `uart_tx_dmareq`

## Requirements
- R1: While rst_ni is low, txd_o is 1 and dma_req_o, tx_irq_o and ovf_o are 0.
- R2: Each frame drives txd_o with one 0 start bit, then data bits 0 to 7 in that order, then one 1 stop bit. Between frames the line rests at 1.
- R3: Every bit lasts 32 × 4^n × (N + 1) clock cycles, where n is prescale_i and N is divisor_i. For example, n=0 and N=0 give 32 cycles, n=0 and N=2 give 96, and n=1 and N=1 give 256.
- R4: The queue holds up to 16 bytes. Bytes are sent in the order they were written, and queued frames follow each other with no more than one idle cycle between them.
- R5: A write while 16 bytes are queued is dropped, and ovf_o becomes 1 one cycle later. ovf_o stays 1 until fifo_clr_i is asserted, which clears it.
- R6: From the cycle after any change, dma_req_o is 1 whenever the fill level is at or below trig_lvl_i, and 0 whenever it is above, except as R7 states. For example, an empty queue with trig_lvl_i = 0 holds dma_req_o at 1.
- R7: In the cycle after an accepted write, dma_req_o is 0 regardless of the fill level.
- R8: While fifo_clr_i is 1, the queue is empty and writes are ignored. No frame follows a write made during the clear.
- R9: While tx_en_i is 0, txd_o is 1 and no byte leaves the queue. Queued bytes start to transmit once tx_en_i is set.
- R10: tx_irq_o equals dma_req_o while irq_en_i is 1 and is 0 while irq_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one byte into the queue |
| wr_data_i | input | 8 | Byte to queue |
| tx_en_i | input | 1 | Transmit enable |
| irq_en_i | input | 1 | Transmit interrupt enable |
| fifo_clr_i | input | 1 | Queue clear, active while high |
| prescale_i | input | 2 | Prescaler code n, divides by 4^n |
| divisor_i | input | 8 | Bit-rate divider value N |
| trig_lvl_i | input | 5 | Fill level at or below which requests are raised |
| txd_o | output | 1 | Serial line, idle high |
| dma_req_o | output | 1 | DMA transfer request |
| tx_irq_o | output | 1 | Transmit interrupt request |
| ovf_o | output | 1 | Sticky queue overflow flag |

## Verification
Timing for these checks is counted in clock edges.

- **Request and overflow:** A write is taken at a rising edge. The request dip and the new request level appear after that same edge and are checked at the next falling edge. The level returns one cycle later. The overflow flag also shows at the first falling edge after the dropped write.
- **Start bit:** The start bit is driven right after the edge that takes a byte from the queue.
- **Data and stop bits:** The bench finds the first low level at a falling edge. It then samples each later bit at the middle of its period, P/2 + k·P cycles after that point, so register delay of up to a few cycles cannot shift a sample across a bit boundary.
- **Bit period:** Bit length is measured directly by counting the falling edges for which the line stays low. An all-ones byte gives exactly P, and an all-zeros byte gives exactly 9·P.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned FRAME_BITS = 10;  // start + 8 data + stop
  localparam int unsigned OVERSAMPLE = 32;

  typedef enum logic {
    SER_IDLE  = 1'b0,
    SER_SHIFT = 1'b1
  } ser_state_e;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned PRESC_W = 2,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned OS      = uart_tx_pkg::OVERSAMPLE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic               bit_tick_o
);
  localparam int unsigned PRE_W = 2 * ((1 << PRESC_W) - 1);
  localparam int unsigned OS_W  = $clog2(OS);

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W:0]   pre_lim_w;
  logic [PRE_W-1:0] pre_lim;
  logic [DIV_W-1:0] div_cnt;
  logic [OS_W-1:0]  os_cnt;
  logic             pre_tick, div_tick;

  // prescaler divides by 4^n
  assign pre_lim_w  = ((PRE_W+1)'(1) << (2 * presc_i)) - (PRE_W+1)'(1);
  assign pre_lim    = pre_lim_w[PRE_W-1:0];
  assign pre_tick   = (pre_cnt == pre_lim);
  assign div_tick   = pre_tick && (div_cnt == div_i);
  assign bit_tick_o = div_tick && (os_cnt == OS_W'(OS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      os_cnt  <= '0;
    end else if (!run_i) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      os_cnt  <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) div_cnt <= div_tick ? '0 : div_cnt + 1'b1;
      if (div_tick) os_cnt  <= bit_tick_o ? '0 : os_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] fill_o,
  output logic [CW-1:0] fill_nxt_o,
  output logic          push_ok_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          pop_ok;

  assign full_o     = (cnt == CW'(DEPTH));
  assign empty_o    = (cnt == '0);
  assign push_ok_o  = push_i && !clr_i && !full_o;
  assign pop_ok     = pop_i && !clr_i && !empty_o;
  assign data_o     = mem[rd_ptr];
  assign fill_o     = cnt;

  always_comb begin
    if (clr_i) fill_nxt_o = '0;
    else begin
      unique case ({push_ok_o, pop_ok})
        2'b10:   fill_nxt_o = cnt + 1'b1;
        2'b01:   fill_nxt_o = cnt - 1'b1;
        default: fill_nxt_o = cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      cnt <= fill_nxt_o;
      if (clr_i) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok_o) wr_ptr <= wr_ptr + 1'b1;
        if (pop_ok)    rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int unsigned W   = 8,
  localparam int unsigned FB = W + 2,
  localparam int unsigned BW = $clog2(FB)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         avail_i,
  input  logic [W-1:0] data_i,
  input  logic         bit_tick_i,
  output logic         pop_o,
  output logic         busy_o,
  output logic         line_o
);
  ser_state_e    state;
  logic [FB-1:0] shreg;
  logic [BW-1:0] bit_idx;

  assign pop_o  = (state == SER_IDLE) && en_i && avail_i;
  assign busy_o = (state == SER_SHIFT);
  assign line_o = busy_o ? shreg[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= SER_IDLE;
      shreg   <= '1;
      bit_idx <= '0;
    end else if (!en_i) begin
      state   <= SER_IDLE;
      shreg   <= '1;
      bit_idx <= '0;
    end else begin
      unique case (state)
        SER_IDLE: if (pop_o) begin
          shreg   <= {1'b1, data_i, 1'b0};
          bit_idx <= '0;
          state   <= SER_SHIFT;
        end
        SER_SHIFT: if (bit_tick_i) begin
          shreg <= {1'b1, shreg[FB-1:1]};
          if (bit_idx == BW'(FB - 1)) state <= SER_IDLE;
          else bit_idx <= bit_idx + 1'b1;
        end
        default: state <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_dmareq.sv
module uart_tx_dmareq #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned W       = 8,
  parameter int unsigned PRESC_W = 2,
  parameter int unsigned DIV_W   = 8,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [W-1:0]       wr_data_i,
  input  logic               tx_en_i,
  input  logic               irq_en_i,
  input  logic               fifo_clr_i,
  input  logic [PRESC_W-1:0] prescale_i,
  input  logic [DIV_W-1:0]   divisor_i,
  input  logic [CW-1:0]      trig_lvl_i,
  output logic               txd_o,
  output logic               dma_req_o,
  output logic               tx_irq_o,
  output logic               ovf_o
);
  logic [W-1:0]  head;
  logic [CW-1:0] fill, fill_nxt;
  logic          wr_acc, full, empty, pop, busy, line, bit_tick;
  logic          req_q, ovf_q;

  uart_tx_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk_i, .rst_ni,
    .clr_i      (fifo_clr_i),
    .push_i     (wr_en_i),
    .data_i     (wr_data_i),
    .pop_i      (pop),
    .data_o     (head),
    .fill_o     (fill),
    .fill_nxt_o (fill_nxt),
    .push_ok_o  (wr_acc),
    .full_o     (full),
    .empty_o    (empty)
  );

  uart_baud_gen #(.PRESC_W(PRESC_W), .DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni,
    .run_i      (busy),
    .presc_i    (prescale_i),
    .div_i      (divisor_i),
    .bit_tick_o (bit_tick)
  );

  uart_tx_serializer #(.W(W)) u_ser (
    .clk_i, .rst_ni,
    .en_i       (tx_en_i),
    .avail_i    (!empty && !fifo_clr_i),
    .data_i     (head),
    .bit_tick_i (bit_tick),
    .pop_o      (pop),
    .busy_o     (busy),
    .line_o     (line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      // forced low for one cycle after each accepted write
      req_q <= (fill_nxt <= trig_lvl_i) && !wr_acc;
      if (fifo_clr_i)          ovf_q <= 1'b0;
      else if (wr_en_i && full) ovf_q <= 1'b1;
    end
  end

  assign txd_o     = line | ~tx_en_i;
  assign dma_req_o = req_q;
  assign tx_irq_o  = req_q & irq_en_i;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/uart_tx_dmareq_chk.sv
module uart_tx_dmareq_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          fifo_clr_i,
  input logic [CW-1:0] trig_lvl_i,
  input logic [CW-1:0] fill,
  input logic          dma_req_o,
  input logic          tx_irq_o,
  input logic          ovf_o,
  input logic          txd_o
);
  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) reset_idle_chk: assert (txd_o && !dma_req_o && !tx_irq_o && !ovf_o);
  end

  // R7
  req_dip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !fifo_clr_i && fill < CW'(DEPTH)) |=> !dma_req_o);

  // R5
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !fifo_clr_i && fill == CW'(DEPTH)) |=> ovf_o);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !fifo_clr_i) |=> ovf_o);

  // R8
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (fill == '0));

  // R6
  req_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(trig_lvl_i) && fill > trig_lvl_i) |-> !dma_req_o);
endmodule

bind uart_tx_dmareq uart_tx_dmareq_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .fifo_clr_i (fifo_clr_i),
  .trig_lvl_i (trig_lvl_i),
  .fill       (fill),
  .dma_req_o  (dma_req_o),
  .tx_irq_o   (tx_irq_o),
  .ovf_o      (ovf_o),
  .txd_o      (txd_o)
);

// File: tb/sim_uart_tx_dmareq.sv
`timescale 1ns/1ps
module sim_uart_tx_dmareq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_en = 1'b0, irq_en = 1'b0, fclr = 1'b0;
  logic [1:0] presc = '0;
  logic [7:0] divv = '0;
  logic [4:0] trig = '0;
  logic       txd, dreq, irq, ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_tx_dmareq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_en_i(tx_en), .irq_en_i(irq_en), .fifo_clr_i(fclr),
    .prescale_i(presc), .divisor_i(divv), .trig_lvl_i(trig),
    .txd_o(txd), .dma_req_o(dreq), .tx_irq_o(irq), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_fifo();
    fclr = 1'b1; cyc(1); fclr = 1'b0; cyc(1);
  endtask

  // wait for start bit at a falling edge; returns 0 on timeout
  task automatic wait_start(input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin seen = 1'b1; break; end
    end
  endtask

  task automatic rx_frame(input int p, input logic [7:0] exp, input string tag);
    bit seen;
    logic [7:0] got;
    wait_start(20 * p, seen);
    chk(seen, {tag, " start seen"}, seen, 1);
    if (seen) begin
      cyc(p / 2);
      chk(txd == 1'b0, {tag, " start bit"}, txd, 0);
      for (int k = 0; k < 8; k++) begin
        cyc(p);
        got[k] = txd;
      end
      chk(got == exp, {tag, " data"}, got, exp);
      cyc(p);
      chk(txd == 1'b1, {tag, " stop bit"}, txd, 1);
    end
  endtask

  task automatic measure_low(input int limit, output int len);
    bit seen;
    len = 0;
    wait_start(limit, seen);
    if (seen) begin
      len = 1;
      while (txd == 1'b0 && len < limit) begin @(negedge clk); if (txd == 1'b0) len++; end
    end
  endtask

  task automatic t_reset();
    cyc(2);
    chk(txd == 1'b1, "R1 txd in reset", txd, 1);
    chk(dreq == 1'b0 && irq == 1'b0, "R1 req in reset", dreq, 0);
    chk(ovf == 1'b0, "R1 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(dreq == 1'b1, "R6 empty trig0 after reset", dreq, 1);
  endtask

  task automatic t_frame();
    presc = 2'd0; divv = 8'd0; tx_en = 1'b1;
    wr(8'hA5);
    rx_frame(32, 8'hA5, "R2 frame A5");
    cyc(40);
    chk(txd == 1'b1, "R2 idle high", txd, 1);
    tx_en = 1'b0;
  endtask

  task automatic t_baud();
    int len;
    tx_en = 1'b1;
    presc = 2'd1; divv = 8'd1;
    wr(8'hFF);
    measure_low(4000, len);
    chk(len == 256, "R3 n1 N1 start length", len, 256);
    cyc(10 * 256);
    presc = 2'd0; divv = 8'd2;
    wr(8'h00);
    measure_low(4000, len);
    chk(len == 9 * 96, "R3 n0 N2 zero byte low span", len, 9 * 96);
    cyc(2 * 96);
    presc = 2'd0; divv = 8'd0;
    tx_en = 1'b0;
  endtask

  task automatic t_order();
    wr(8'h31); wr(8'hC6); wr(8'h5A);
    cyc(50);
    chk(txd == 1'b1, "R9 disabled line idle", txd, 1);
    tx_en = 1'b1;
    rx_frame(32, 8'h31, "R4 first");
    rx_frame(32, 8'hC6, "R4 second");
    rx_frame(32, 8'h5A, "R4 third");
    cyc(40);
    tx_en = 1'b0;
  endtask

  task automatic t_dma();
    clear_fifo();
    trig = 5'd1;
    cyc(1);
    chk(dreq == 1'b1, "R6 empty at trig1", dreq, 1);
    wr(8'h11);
    chk(dreq == 1'b0, "R7 dip after write", dreq, 0);
    cyc(1);
    chk(dreq == 1'b1, "R6 fill1 at trig1", dreq, 1);
    wr(8'h22);
    cyc(2);
    chk(dreq == 1'b0, "R6 fill2 above trig1", dreq, 0);
    trig = 5'd2;
    cyc(1);
    chk(dreq == 1'b1, "R6 fill2 at trig2", dreq, 1);
    irq_en = 1'b1;
    #1;
    chk(irq == 1'b1, "R10 irq with enable", irq, 1);
    irq_en = 1'b0;
    #1;
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
    trig = 5'd0;
    clear_fifo();
  endtask

  task automatic t_ovf();
    clear_fifo();
    trig = 5'd16;
    for (int i = 0; i < 16; i++) wr(8'(i));
    chk(ovf == 1'b0, "R5 no ovf at 16", ovf, 0);
    wr(8'hEE);
    chk(ovf == 1'b1, "R5 ovf on 17th", ovf, 1);
    cyc(5);
    chk(ovf == 1'b1, "R5 ovf sticky", ovf, 1);
    tx_en = 1'b1;
    for (int i = 0; i < 16; i++) rx_frame(32, 8'(i), "R4 full queue order");
    cyc(40);
    tx_en = 1'b0;
    chk(ovf == 1'b1, "R5 ovf still set", ovf, 1);
    trig = 5'd0;
    fclr = 1'b1;
    wr(8'h77);
    chk(ovf == 1'b0, "R5 ovf cleared", ovf, 0);
    chk(dreq == 1'b1, "R8 write ignored in clear", dreq, 1);
    fclr = 1'b0;
    tx_en = 1'b1;
    begin
      bit seen;
      wait_start(400, seen);
      chk(!seen, "R8 no frame after clear", seen, 0);
    end
    tx_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_frame();
    t_baud();
    t_order();
    t_dma();
    t_ovf();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule